// File: doc/BRIEF.md
# Shared Miss Tracker for a Four-Core Non-Blocking Cache

This block keeps track of the cache misses that a shared last-level cache has sent downstream and not yet had answered. Each core presents one access per cycle: a valid bit, a line address, and a hit/miss verdict from a tag lookup outside this block. It also carries a dirty flag and a victim address for misses that evict a modified line. A round-robin arbiter accepts at most one access per cycle. A miss to a line that is not yet tracked takes a free entry from a single pool that all cores share. That miss issues a line-fill read tagged with the entry index. When the miss evicts a dirty line, a write-back is issued with it.

A miss to a line that already has a live entry joins that entry and issues no new read. A response carrying an entry's tag frees the entry. On the next cycle the block names every core that was waiting on that line. If the pool is full, the block refuses every access from every core, hits included. As a result, misses from one core can hold off hits from another core. Each core has a counter of the cycles it spent refused this way. The block also reports how many entries are live.

Top module: `mshr_pool`

## Requirements
- R1: After a synchronous active-high reset, no entry is live, occupancy is 0, no fill, write-back or completion is signalled, every stall counter is 0, and the arbiter's rotation starts at core 0.
- R2: When the pool is not full, exactly one requesting core is granted per cycle, and `req_ready` is high only for that core. The search starts at the core after the one granted last and runs in increasing index order, wrapping around.
- R3: A granted miss whose line has no live entry takes the lowest-numbered free entry. On the next cycle it raises `fill_valid`, with `fill_addr` equal to the line and `fill_tag` equal to the entry index.
- R4: When such an allocating miss has `req_dirty` set, `wb_valid` rises in the same cycle as its fill, with `wb_addr` equal to the victim address. Merges and hits never produce a write-back.
- R5: A granted miss to a line whose entry is live, and is not being freed in that same cycle, adds the core to that entry's requester set and issues no fill.
- R6: A granted hit is accepted (ready high) and causes no fill, write-back or change in occupancy.
- R7: While all DEPTH entries are live, `req_ready` is low for every core, whether its access would hit or miss. This holds even in a cycle where a response frees an entry.
- R8: A response with `rsp_valid` and a live `rsp_tag` frees that entry. On the next cycle `done_mask` holds the entry's requester set (bit c for core c), and `done_addr` holds its line.
- R9: A core's stall counter (CW bits, slice c of `stall_cnt`) increments on each cycle in which that core has a valid access and the pool is full. Losing arbitration does not count.
- R10: `occupancy` equals the number of live entries after each clock edge and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCORE | Per-core access valid |
| req_addr | input | NCORE*AW | Per-core line address, core c at slice c |
| req_hit | input | NCORE | Per-core tag-lookup hit flag |
| req_dirty | input | NCORE | Per-core flag: miss evicts a dirty victim |
| req_victim | input | NCORE*AW | Per-core victim line address |
| req_ready | output | NCORE | Per-core accept (at most one high) |
| fill_valid | output | 1 | Line-fill read issued |
| fill_addr | output | AW | Line of the fill read |
| fill_tag | output | TW | Entry index carried with the fill |
| wb_valid | output | 1 | Write-back issued |
| wb_addr | output | AW | Victim line written back |
| rsp_valid | input | 1 | Fill response returned |
| rsp_tag | input | TW | Entry index of the response |
| done_mask | output | NCORE | Cores whose pending miss completed |
| done_addr | output | AW | Line that completed |
| occupancy | output | OW | Number of live entries |
| stall_cnt | output | NCORE*CW | Per-core refused-cycle counters |

## Verification
The hardest state to reach is a full pool that has live requests on it. It matters most when it coincides with hits from other cores, merges, and responses arriving in the same cycle. The stimulus draws addresses from a pool of about a dozen lines so that merges are frequent. It alternates long stretches of sparse responses, which drive the pool to exhaustion and keep it there, with stretches of dense responses that drain it. A directed prologue first fills all entries from one core and then shows hits from the other cores being refused. It then frees one entry and shows that a merged entry reports two requesters on completion.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_HIT   = 2'd1,
    ACC_MERGE = 2'd2,
    ACC_ALLOC = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mshr_rr_arb.sv
module mshr_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q;
  logic          found;
  int            idx;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(ptr_q) + k) % N;
      if (!found && en && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      for (int k = 0; k < N; k++)
        if (gnt[k]) ptr_q <= PW'((k + 1) % N);
    end
  end

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R2
  grant_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
endmodule

// File: rtl/mshr_table.sv
module mshr_table #(
  parameter int NCORE = 4,
  parameter int DEPTH = 11,
  parameter int AW    = 16,
  parameter int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [AW-1:0]    in_addr,
  input  logic [NCORE-1:0] in_who,
  input  logic             rsp_valid,
  input  logic [TW-1:0]    rsp_tag,
  output logic             full,
  output logic             merge_hit,
  output logic             fill_valid,
  output logic [AW-1:0]    fill_addr,
  output logic [TW-1:0]    fill_tag,
  output logic [NCORE-1:0] done_mask,
  output logic [AW-1:0]    done_addr,
  output logic [OW-1:0]    occupancy
);
  logic [DEPTH-1:0] vld_q, vld_d;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [NCORE-1:0] who_q  [DEPTH];
  logic [TW-1:0]    match_idx, free_idx;
  logic             have_free;
  logic [OW-1:0]    cnt_d;

  always_comb begin
    merge_hit = 1'b0;
    match_idx = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && addr_q[i] == in_addr && !(rsp_valid && rsp_tag == TW'(i))
          && !merge_hit) begin
        merge_hit = 1'b1;
        match_idx = TW'(i);
      end
      if (!vld_q[i] && !have_free) begin
        have_free = 1'b1;
        free_idx  = TW'(i);
      end
    end
    full = !have_free;
  end

  always_comb begin
    vld_d = vld_q;
    for (int i = 0; i < DEPTH; i++)
      if (rsp_valid && rsp_tag == TW'(i)) vld_d[i] = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (in_valid && !merge_hit && have_free && free_idx == TW'(i)) vld_d[i] = 1'b1;
    cnt_d = '0;
    for (int i = 0; i < DEPTH; i++) cnt_d = cnt_d + OW'(vld_d[i]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (in_valid && merge_hit && match_idx == TW'(i))
        who_q[i] <= who_q[i] | in_who;
      if (in_valid && !merge_hit && have_free && free_idx == TW'(i)) begin
        who_q[i]  <= in_who;
        addr_q[i] <= in_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      occupancy  <= '0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_tag   <= '0;
      done_mask  <= '0;
      done_addr  <= '0;
    end else begin
      vld_q      <= vld_d;
      occupancy  <= cnt_d;
      fill_valid <= in_valid && !merge_hit && have_free;
      fill_addr  <= in_addr;
      fill_tag   <= free_idx;
      done_mask  <= '0;
      for (int i = 0; i < DEPTH; i++)
        if (rsp_valid && rsp_tag == TW'(i)) begin
          done_mask <= who_q[i];
          done_addr <= addr_q[i];
        end
    end
  end

  // R10
  occ_cap_chk: assert property (@(posedge clk) disable iff (rst) occupancy <= OW'(DEPTH));
  // R3
  fill_src_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> ($past(in_valid) && !$past(merge_hit)));
  // R8
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    (|done_mask) |-> $past(rsp_valid));
endmodule

// File: rtl/mshr_stall_ctr.sv
module mshr_stall_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R9
  stall_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(inc) |-> $stable(count));
endmodule

// File: rtl/mshr_pool.sv
module mshr_pool
  import mshr_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int DEPTH = 11,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int TW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCORE-1:0]    req_valid,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE-1:0]    req_hit,
  input  logic [NCORE-1:0]    req_dirty,
  input  logic [NCORE*AW-1:0] req_victim,
  output logic [NCORE-1:0]    req_ready,
  output logic                fill_valid,
  output logic [AW-1:0]       fill_addr,
  output logic [TW-1:0]       fill_tag,
  output logic                wb_valid,
  output logic [AW-1:0]       wb_addr,
  input  logic                rsp_valid,
  input  logic [TW-1:0]       rsp_tag,
  output logic [NCORE-1:0]    done_mask,
  output logic [AW-1:0]       done_addr,
  output logic [OW-1:0]       occupancy,
  output logic [NCORE*CW-1:0] stall_cnt
);
  logic [NCORE-1:0] gnt;
  logic             pool_full, merge_hit;
  logic [AW-1:0]    sel_addr, sel_victim;
  logic             sel_hit, sel_dirty;
  acc_kind_e        kind;

  mshr_rr_arb #(.N(NCORE)) u_arb (
    .clk(clk), .rst(rst), .req(req_valid), .en(!pool_full), .gnt(gnt)
  );

  always_comb begin
    sel_addr   = '0;
    sel_victim = '0;
    sel_hit    = 1'b0;
    sel_dirty  = 1'b0;
    for (int c = 0; c < NCORE; c++)
      if (gnt[c]) begin
        sel_addr   = req_addr[c*AW +: AW];
        sel_victim = req_victim[c*AW +: AW];
        sel_hit    = req_hit[c];
        sel_dirty  = req_dirty[c];
      end
    if (gnt == '0)   kind = ACC_NONE;
    else if (sel_hit) kind = ACC_HIT;
    else if (merge_hit) kind = ACC_MERGE;
    else             kind = ACC_ALLOC;
  end

  assign req_ready = gnt;

  mshr_table #(.NCORE(NCORE), .DEPTH(DEPTH), .AW(AW), .TW(TW), .OW(OW)) u_tab (
    .clk(clk), .rst(rst),
    .in_valid(kind == ACC_MERGE || kind == ACC_ALLOC),
    .in_addr(sel_addr), .in_who(gnt),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .full(pool_full), .merge_hit(merge_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_tag(fill_tag),
    .done_mask(done_mask), .done_addr(done_addr), .occupancy(occupancy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
    end else begin
      wb_valid <= (kind == ACC_ALLOC) && sel_dirty;
      wb_addr  <= sel_victim;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_stall
    mshr_stall_ctr #(.CW(CW)) u_ctr (
      .clk(clk), .rst(rst),
      .inc(req_valid[c] && pool_full),
      .count(stall_cnt[c*CW +: CW])
    );
  end

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    pool_full |-> (req_ready == '0));
  // R4
  wb_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> fill_valid);
endmodule

// File: tb/mshr_pool_test.sv
module mshr_pool_test;
  localparam int NC = 4, DEPTH = 11, AW = 16, CW = 16;
  localparam int TW = $clog2(DEPTH), OW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [NC-1:0] req_valid, req_hit, req_dirty, req_ready, done_mask;
  logic [NC*AW-1:0] req_addr, req_victim;
  logic [NC*CW-1:0] stall_cnt;
  logic fill_valid, wb_valid, rsp_valid;
  logic [AW-1:0] fill_addr, wb_addr, done_addr;
  logic [TW-1:0] fill_tag, rsp_tag;
  logic [OW-1:0] occupancy;

  mshr_pool #(.NCORE(NC), .DEPTH(DEPTH), .AW(AW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_hit(req_hit), .req_dirty(req_dirty), .req_victim(req_victim),
    .req_ready(req_ready), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_tag(fill_tag), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .done_mask(done_mask),
    .done_addr(done_addr), .occupancy(occupancy), .stall_cnt(stall_cnt)
  );

  int n_cmp = 0, n_bad = 0;

  // stimulus for the next cycle
  bit [NC-1:0] b_v, b_h, b_d;
  logic [AW-1:0] b_a [NC];
  logic [AW-1:0] b_vic [NC];
  bit b_rv;
  int b_rt;

  // reference model state
  bit mv [DEPTH];
  logic [AW-1:0] ma [DEPTH];
  logic [NC-1:0] mw [DEPTH];
  int rr = 0;
  int mstall [NC];
  bit e_fv, e_wv;
  logic [AW-1:0] e_fa, e_wa, e_da;
  int e_ft, e_occ;
  logic [NC-1:0] e_dm;
  string fill_lbl;

  task automatic chk(input string lbl, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  function automatic int live_count();
    int n = 0;
    for (int i = 0; i < DEPTH; i++) n += mv[i];
    return n;
  endfunction

  function automatic int pick_grant(input bit [NC-1:0] v, input bit full);
    if (full) return -1;
    for (int k = 0; k < NC; k++)
      if (v[(rr + k) % NC]) return (rr + k) % NC;
    return -1;
  endfunction

  // called at a negedge; runs one clock and checks everything
  task automatic do_cycle();
    bit full;
    int g, j, k;
    req_valid = b_v; req_hit = b_h; req_dirty = b_d;
    for (int c = 0; c < NC; c++) begin
      req_addr[c*AW +: AW]   = b_a[c];
      req_victim[c*AW +: AW] = b_vic[c];
    end
    rsp_valid = b_rv;
    rsp_tag   = TW'(b_rt);
    #1;
    full = (live_count() == DEPTH);
    g = pick_grant(b_v, full);
    for (int c = 0; c < NC; c++)
      chk(full ? "R7 ready while full" : "R2 ready", req_ready[c], (g == c));
    for (int c = 0; c < NC; c++) if (b_v[c] && full) mstall[c]++;
    e_fv = 0; e_wv = 0; e_dm = '0; fill_lbl = "R3 fill_valid";
    if (b_rv) begin e_dm = mw[b_rt]; e_da = ma[b_rt]; end
    if (g >= 0) begin
      rr = (g + 1) % NC;
      if (b_h[g]) fill_lbl = "R6 hit no fill";
      else begin
        j = -1;
        for (int i = 0; i < DEPTH; i++)
          if (j < 0 && mv[i] && ma[i] == b_a[g] && !(b_rv && b_rt == i)) j = i;
        if (j >= 0) begin
          mw[j][g] = 1'b1;
          fill_lbl = "R5 merge no fill";
        end else begin
          k = -1;
          for (int i = 0; i < DEPTH; i++) if (k < 0 && !mv[i]) k = i;
          mv[k] = 1; ma[k] = b_a[g]; mw[k] = '0; mw[k][g] = 1'b1;
          e_fv = 1; e_fa = b_a[g]; e_ft = k;
          e_wv = b_d[g]; e_wa = b_vic[g];
        end
      end
    end
    if (b_rv) mv[b_rt] = 0;
    e_occ = live_count();
    @(posedge clk);
    @(negedge clk);
    chk(fill_lbl, fill_valid, e_fv);
    if (e_fv) begin
      chk("R3 fill_addr", fill_addr, e_fa);
      chk("R3 fill_tag", fill_tag, e_ft);
    end
    chk("R4 wb_valid", wb_valid, e_wv);
    if (e_wv) chk("R4 wb_addr", wb_addr, e_wa);
    chk("R8 done_mask", done_mask, e_dm);
    if (e_dm != '0) chk("R8 done_addr", done_addr, e_da);
    chk("R10 occupancy", occupancy, e_occ);
    for (int c = 0; c < NC; c++)
      chk("R9 stall_cnt", stall_cnt[c*CW +: CW], mstall[c]);
  endtask

  task automatic idle_inputs();
    b_v = '0; b_h = '0; b_d = '0; b_rv = 0; b_rt = 0;
    for (int c = 0; c < NC; c++) begin b_a[c] = '0; b_vic[c] = '0; end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; ma[i] = '0; mw[i] = '0; end
    for (int c = 0; c < NC; c++) mstall[c] = 0;
    idle_inputs();
    rst = 1'b1;
    req_valid = '0; req_hit = '0; req_dirty = '0; req_addr = '0; req_victim = '0;
    rsp_valid = 1'b0; rsp_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 occupancy", occupancy, 0);
    chk("R1 fill_valid", fill_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 done_mask", done_mask, 0);
    chk("R1 stall_cnt", stall_cnt, 0);

    // directed: core 0 fills the whole pool with distinct lines, every 3rd dirty
    for (int n = 0; n < DEPTH; n++) begin
      idle_inputs();
      b_v[0] = 1; b_a[0] = AW'(16'h100 + n); b_d[0] = (n % 3 == 0);
      b_vic[0] = AW'(16'h800 + n);
      do_cycle();
    end
    // R7: full pool refuses hits from every core
    idle_inputs();
    b_v = '1; b_h = '1;
    do_cycle();
    // response for entry 3 in a full cycle: still refused (R7), freed (R8)
    idle_inputs();
    b_v = 4'b0010; b_h = 4'b0010; b_rv = 1; b_rt = 3;
    do_cycle();
    // R5: core 1 misses on line of entry 0 -> merge
    idle_inputs();
    b_v = 4'b0010; b_a[1] = 16'h100;
    do_cycle();
    // R8: entry 0 completes with two requesters
    idle_inputs();
    b_rv = 1; b_rt = 0;
    do_cycle();

    // random phases
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int rp, live, pick;
      rp = ((cyc / 250) % 2 == 1) ? 70 : 8;
      idle_inputs();
      for (int c = 0; c < NC; c++) begin
        b_v[c]   = ($urandom % 100) < 60;
        b_h[c]   = ($urandom % 100) < 30;
        b_d[c]   = ($urandom % 100) < 30;
        b_a[c]   = AW'($urandom % 12);
        b_vic[c] = AW'($urandom);
      end
      live = live_count();
      if (live > 0 && ($urandom % 100) < rp) begin
        pick = $urandom % live;
        for (int i = 0; i < DEPTH; i++)
          if (mv[i]) begin
            if (pick == 0) begin b_rv = 1; b_rt = i; end
            pick--;
          end
      end
      do_cycle();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule